// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Controller

This block sits between an on-chip requester and an external asynchronous static RAM. The RAM has a 19-bit address, an 8-bit data bus and three active-low strobes: select, write and output enable. The requester presents one byte read or write at a time over a valid/ready handshake. The controller then plays out a pin sequence whose phase lengths are computed at elaboration from the clock period and from the RAM's nanosecond limits. Read data comes back as a byte with a one-cycle valid strobe.

Each access starts with a setup cycle in which the new address is placed on the pins while every strobe is high. A strobe window follows, then a closing phase. Writes are ended by the write strobe. The output enable stays high throughout a write, and the controller drives the data pins only while the write strobe is low. After every read, the controller holds all strobes high for a bus-release gap. This gap keeps its own drivers off until the RAM has stopped driving.

The data bus is split into an output byte, an input byte and a drive enable. The pad ring joins them into the bidirectional pins. All pin-side outputs come straight from flops.

Top module: `sram_bridge`

## Requirements
- R1: After reset, the select, write and output-enable strobes are high, the drive enable is low, ready is high and the read-valid strobe is low.
- R2: The address pins change value only on a clock edge where the select and write strobes are high both before and after that edge.
- R3: With the default 4 ns clock, a write holds select and write strobe low together for exactly 13 cycles. This covers the 45 ns pulse, 50 ns address and select lead, and 20 ns turn-off plus 25 ns setup. Across that window the request byte is driven and the output enable stays high.
- R4: A write returns ready 15 cycles after the accepting edge, which keeps the cycle at 55 ns or longer. The stored byte is returned by a later read of the same address.
- R5: A read holds select and output enable low with the write strobe high for exactly 14 cycles. The data pins are sampled on the edge that ends this window. The read-valid strobe is high for exactly one cycle, 15 cycles after the accepting edge, and carries the sampled byte.
- R6: After a read, all strobes stay high for 5 cycles before ready returns, 20 cycles after acceptance. The drive enable is never high within 5 cycles of the output enable being low.
- R7: Ready falls on the edge that accepts a request and stays low until the sequence is back in idle.
- R8: The drive enable is high only while select and write strobe are low and output enable is high.
- R9: The output enable is low only while select is low and the write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 19 | RAM address pins |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Byte driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Byte received from the RAM |

## Verification
A wrong phase count or a stuck state shows at the ports within one access. A read window that is one cycle short samples the model's not-yet-valid filler byte. A pulse of the wrong length changes the measured write window and moves ready. A lost bus-release gap either brings ready back 5 cycles early or raises the drive enable beside a recently active output enable. An address register loaded at the wrong time is flagged at the next edge where strobes are low. A corrupted write shows up as a wrong byte on the read that follows.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOV,
    ST_RD_SETUP,
    ST_RD_ACCESS,
    ST_RD_TURN
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Ceiling of ns over the clock period; zero stays zero.
  function automatic int ns_to_cycles(input int ns, input int period);
    if (ns <= 0) return 0;
    return (ns + period - 1) / period;
  endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_bridge_pkg::*;
#(
  parameter int WP_CYC   = 13,
  parameter int REC_CYC  = 1,
  parameter int RD_CYC   = 14,
  parameter int TURN_CYC = 5,
  parameter int CNT_W    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_write,
  output seq_state_e state_q,
  output seq_state_e state_d,
  output logic       phase_last,
  output logic       accept
);

  localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD  = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             load_en;

  assign phase_last = (cnt_q == '0);
  assign accept     = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d  = state_q;
    load_en  = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
      end
      ST_WR_SETUP: begin
        state_d  = ST_WR_PULSE;
        load_en  = 1'b1;
        load_val = WP_LOAD;
      end
      ST_WR_PULSE: begin
        if (phase_last) begin
          state_d  = ST_WR_RECOV;
          load_en  = 1'b1;
          load_val = REC_LOAD;
        end
      end
      ST_WR_RECOV: begin
        if (phase_last) state_d = ST_IDLE;
      end
      ST_RD_SETUP: begin
        state_d  = ST_RD_ACCESS;
        load_en  = 1'b1;
        load_val = RD_LOAD;
      end
      ST_RD_ACCESS: begin
        if (phase_last) begin
          state_d  = ST_RD_TURN;
          load_en  = 1'b1;
          load_val = TURN_LOAD;
        end
      end
      ST_RD_TURN: begin
        if (phase_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_en)          cnt_q <= load_val;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/sram_pins.sv
module sram_pins
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state_d,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  logic nxt_wr, nxt_rd;

  assign nxt_wr = (state_d == ST_WR_PULSE);
  assign nxt_rd = (state_d == ST_RD_ACCESS);

  // Address and write byte only move while idle, so strobes are high.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      if (req_write) mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_ce_n  <= !(nxt_wr || nxt_rd);
      mem_we_n  <= !nxt_wr;
      mem_oe_n  <= !nxt_rd;
      mem_dq_oe <= nxt_wr;
    end
  end

endmodule

// File: rtl/sram_capture.sv
module sram_capture
  import sram_bridge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state_q,
  input  logic              phase_last,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic fire;

  assign fire = (state_q == ST_RD_ACCESS) && phase_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_WP_NS       = 45,
  parameter int T_AW_NS       = 50,
  parameter int T_WHZ_NS      = 20,
  parameter int T_DW_NS       = 25,
  parameter int T_WC_NS       = 55,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_HZ_NS       = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int WP_NS    = imax(imax(T_WP_NS, T_AW_NS), T_WHZ_NS + T_DW_NS);
  localparam int WP_CYC   = imax(1, ns_to_cycles(WP_NS, CLK_PERIOD_NS));
  localparam int REC_CYC  = imax(1, ns_to_cycles(T_WC_NS, CLK_PERIOD_NS) - 1 - WP_CYC);
  localparam int RD_CYC   = imax(1, ns_to_cycles(imax(T_RC_NS, T_AA_NS), CLK_PERIOD_NS));
  localparam int TURN_CYC = imax(1, ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS));
  localparam int MAX_CYC  = imax(imax(WP_CYC, REC_CYC), imax(RD_CYC, TURN_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  seq_state_e state_q, state_d;
  logic       phase_last;
  logic       accept;

  assign req_ready = (state_q == ST_IDLE);

  sram_seq #(
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC),
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .state_q   (state_q),
    .state_d   (state_d),
    .phase_last(phase_last),
    .accept    (accept)
  );

  sram_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .state_d   (state_d),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
  );

  sram_capture #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk       (clk),
    .rst       (rst),
    .state_q   (state_q),
    .phase_last(phase_last),
    .mem_dq_in (mem_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int ADDR_W   = 19,
  parameter int WP_CYC   = 13,
  parameter int TURN_CYC = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  logic [15:0] we_lo_cnt;
  logic [15:0] oe_hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo_cnt <= '0;
      oe_hi_cnt <= 16'(TURN_CYC);
    end else begin
      we_lo_cnt <= mem_we_n ? 16'd0 : we_lo_cnt + 16'd1;
      if (!mem_oe_n)                   oe_hi_cnt <= '0;
      else if (oe_hi_cnt != 16'hFFFF)  oe_hi_cnt <= oe_hi_cnt + 16'd1;
    end
  end

  // R2
  addr_move_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_addr != $past(mem_addr)) |->
      (mem_ce_n && mem_we_n && $past(mem_ce_n) && $past(mem_we_n)));

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo_cnt == 16'(WP_CYC)));

  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R6
  bus_release_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (oe_hi_cnt >= 16'(TURN_CYC)));

  // R7
  busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  drive_window_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_ce_n && !mem_we_n && mem_oe_n));

  // R9
  read_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

endmodule

bind sram_bridge sram_bridge_chk #(
  .ADDR_W  (ADDR_W),
  .WP_CYC  (WP_CYC),
  .TURN_CYC(TURN_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_addr (mem_addr),
  .mem_ce_n (mem_ce_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_bridge_bench.sv
module sram_bridge_bench;

  localparam int WP   = 13;
  localparam int RD   = 14;
  localparam int TURN = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sram_bridge u_sram_bridge (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // RAM model and pin monitors, sampled mid-cycle.
  logic [7:0]  ram [int];
  int          rd_cnt = 0, wp_cnt = 0, last_wp = 0, oe_hi = 100;
  int          viol_addr = 0, viol_wr = 0, viol_turn = 0;
  logic [7:0]  wdat = '0;
  logic [18:0] prev_addr = '0;
  logic        prev_ce = 1'b1, prev_we = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_cnt = rd_cnt + 1;
      else rd_cnt = 0;
      if (rd_cnt >= RD)
        mem_dq_in = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
      else
        mem_dq_in = 8'hEE;
      if (!mem_ce_n && !mem_we_n) begin
        wp_cnt = wp_cnt + 1;
        if (!mem_dq_oe || !mem_oe_n) viol_wr = viol_wr + 1;
        wdat = mem_dq_out;
      end else if (wp_cnt != 0) begin
        last_wp = wp_cnt;
        ram[int'(mem_addr)] = wdat;
        wp_cnt = 0;
      end
      if (!mem_oe_n) oe_hi = 0;
      else if (oe_hi < 100) oe_hi = oe_hi + 1;
      if (mem_dq_oe && oe_hi < TURN) viol_turn = viol_turn + 1;
      if (mem_addr !== prev_addr && !(mem_ce_n && mem_we_n && prev_ce && prev_we))
        viol_addr = viol_addr + 1;
    end
    prev_addr = mem_addr;
    prev_ce   = mem_ce_n;
    prev_we   = mem_we_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 ready low after accept", int'(req_ready), 0);
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    int n = 0;
    issue(1'b1, a, d);
    while (!req_ready && n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk("R4 write ready latency", n, 15);
    chk("R3 write pulse cycles", last_wp, WP);
  endtask

  task automatic do_read(input logic [18:0] a, input logic [7:0] exp);
    int n = 0, at = -1, pulses = 0;
    logic [7:0] got = '0;
    issue(1'b0, a, 8'h00);
    while (!req_ready && n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (rsp_valid) begin pulses++; at = n; got = rsp_rdata; end
    end
    chk("R5 rsp_valid timing", at, 15);
    chk("R5 rsp_valid single pulse", pulses, 1);
    chk("R5 read data", int'(got), int'(exp));
    chk("R6 read ready latency", n, 20);
  endtask

  task automatic t_reset;
    chk("R1 ce_n", int'(mem_ce_n), 1);
    chk("R1 we_n", int'(mem_we_n), 1);
    chk("R1 oe_n", int'(mem_oe_n), 1);
    chk("R1 dq_oe", int'(mem_dq_oe), 0);
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_round_trip;
    do_write(19'h00123, 8'hA5);
    do_read(19'h00123, 8'hA5);
  endtask

  task automatic t_patterns;
    do_write(19'h00000, 8'h00);
    do_write(19'h7FFFF, 8'hFF);
    do_write(19'h2AAAA, 8'h55);
    do_write(19'h55555, 8'hAA);
    do_read(19'h7FFFF, 8'hFF);
    do_read(19'h00000, 8'h00);
    do_read(19'h55555, 8'hAA);
    do_read(19'h2AAAA, 8'h55);
  endtask

  task automatic t_turnaround;
    do_read(19'h00123, 8'hA5);
    do_write(19'h00124, 8'h3C);
    do_read(19'h00124, 8'h3C);
    do_read(19'h00123, 8'hA5);
  endtask

  task automatic t_overwrite;
    do_write(19'h01000, 8'h11);
    do_write(19'h01000, 8'h96);
    do_read(19'h01000, 8'h96);
    do_read(19'h03333, 8'h00);
  endtask

  task automatic t_monitors;
    chk("R2 address moved under strobe", viol_addr, 0);
    chk("R3 data or oe_n wrong in pulse", viol_wr, 0);
    chk("R6 drive too soon after read", viol_turn, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_round_trip();
    t_patterns();
    t_turnaround();
    t_overwrite();
    t_monitors();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule